// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block is an interrupt controller with eight request inputs for an 8086-class processor. Software sets it up through a byte-wide port with one address line. An even-address write with data bit 4 set starts a fresh initialization. Then come up to three more odd-address words: the vector base, then the cascade word and the mode word. Each of those two is taken only when the first word asks for it. After that, odd-address writes and reads go to the mask register.

Requests are latched on a rising edge, or follow the input level, as the first init word selects. Resolution is fixed-priority, with input 0 the most urgent. An input is offered to the CPU only when it is unmasked and outranks everything now in service. While the acknowledge strobe is high, the block drives the vector: the base in the upper five bits and the input number in the lower three. Servicing ends in one of two ways: an explicit non-specific end-of-interrupt command, or automatically at acknowledge. The SP/EN pin has two roles. In buffered mode it is an output that marks data-bus drive, and the role comes from the mode word. Otherwise it is an input strap that selects master or slave.

Top module: `pic8_core`

## Requirements
- R1: An even-address write with data bit 4 set begins initialization. It clears the mask, in-service and request state, and `int_o` stays low until the sequence completes.
- R2: In the first init word, bit 1 means single (no cascade word) and bit 0 means a mode word follows. After the base word, the cascade word is taken only if bit 1 is clear, and the mode word only if bit 0 is set. The next odd write loads the mask.
- R3: While `inta_i` is high, `dout_o` equals {base word bits 7:3, winning input index}.
- R4: The mask is written and read at the odd address once initialization is complete. A set bit keeps its input from raising `int_o`.
- R5: Input 0 has the highest priority. A request raises `int_o` only if it is unmasked and its index is lower than every in-service index.
- R6: When mode-word bit 1 is clear, an acknowledge sets the winner's in-service bit. An even-address write of 0x20 clears the lowest-index in-service bit.
- R7: When mode-word bit 1 is set, acknowledge sets no in-service bit, so the same input may fire again without a command.
- R8: In edge mode (first-word bit 3 clear), a rising input edge latches a request that acknowledge clears. An input held high across initialization needs a new edge.
- R9: In level mode (first-word bit 3 set), the request follows the input. It is re-raised one cycle after acknowledge if the input is still high, and withdrawn when the input falls.
- R10: When mode-word bit 3 is set (buffered), `spen_oe_o` is high and `spen_o` is high exactly while the block drives data. Mode-word bit 2 sets `master_o`.
- R11: When buffered mode is off, `spen_oe_o` is low and `master_o` follows `spen_i`.
- R12: An even-address read returns the request register, masked inputs included. `dout_en_o` is high during any read or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| a0_i | input | 1 | Address bit 0 |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data or vector |
| dout_en_o | output | 1 | Block drives data this cycle |
| ir_i | input | 8 | Interrupt request inputs |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| int_o | output | 1 | Interrupt to CPU |
| spen_i | input | 1 | Master/slave strap (non-buffered) |
| spen_o | output | 1 | Buffer enable (buffered) |
| spen_oe_o | output | 1 | Output enable for the SP/EN pin |
| master_o | output | 1 | Resolved master role |

## Verification
An input edge reaches `int_o` one clock edge later. Register writes and end-of-interrupt commands show at the ports after the edge that takes them. Vectors and read data are combinational, so they are valid in the same cycle as `inta_i` or `rd_i`. The bench drives on falling edges and samples 1 ns after raising a strobe, or at the next falling edge for registered effects. In level mode, the request comes back two edges after acknowledge, and the bench waits one extra cycle before checking it.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int N_IRQ = 8;
  localparam int IDX_W = $clog2(N_IRQ);
  localparam int DW    = 8;
  localparam int BASE_W = DW - IDX_W;
  localparam logic [2:0] OCW_EOI_NS = 3'b001;

  typedef enum logic [2:0] {ST_OFF, ST_ICW2, ST_ICW3, ST_ICW4, ST_RUN} init_st_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // lowest set index wins
  function automatic pick_t pick_first(input logic [N_IRQ-1:0] v);
    pick_t p;
    p = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/pic8_init.sv
module pic8_init
  import pic8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DW-1:0]     din_i,
  output logic              ready_o,
  output logic              clr_o,
  output logic              eoi_o,
  output logic [BASE_W-1:0] base_o,
  output logic              level_o,
  output logic              aeoi_o,
  output logic              buf_o,
  output logic              ms_o,
  output logic [N_IRQ-1:0]  imr_o
);
  init_st_e st_q;
  logic single_q, need4_q;

  assign clr_o   = wr_i & ~a0_i & din_i[4];
  assign ready_o = (st_q == ST_RUN);
  assign eoi_o   = wr_i & ~a0_i & ~din_i[4] & ~din_i[3] &
                   (din_i[7:5] == OCW_EOI_NS) & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      base_o   <= '0;
      level_o  <= 1'b0;
      aeoi_o   <= 1'b0;
      buf_o    <= 1'b0;
      ms_o     <= 1'b0;
      imr_o    <= '0;
    end else if (clr_o) begin
      st_q     <= ST_ICW2;
      single_q <= din_i[1];
      need4_q  <= din_i[0];
      level_o  <= din_i[3];
      aeoi_o   <= 1'b0;
      buf_o    <= 1'b0;
      ms_o     <= 1'b0;
      imr_o    <= '0;
    end else if (wr_i && a0_i) begin
      case (st_q)
        ST_ICW2: begin
          base_o <= din_i[DW-1:IDX_W];
          if (!single_q)    st_q <= ST_ICW3;
          else if (need4_q) st_q <= ST_ICW4;
          else              st_q <= ST_RUN;
        end
        // cascade word accepted, no cascade bus here
        ST_ICW3: st_q <= need4_q ? ST_ICW4 : ST_RUN;
        ST_ICW4: begin
          aeoi_o <= din_i[1];
          ms_o   <= din_i[2];
          buf_o  <= din_i[3];
          st_q   <= ST_RUN;
        end
        ST_RUN:  imr_o <= din_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic8_irr.sv
module pic8_irr
  import pic8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             level_i,
  input  logic [N_IRQ-1:0] ir_i,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_IRQ-1:0] irr_o
);
  logic [N_IRQ-1:0] prev_q, irr_d, ack_mask;

  always_comb begin
    ack_mask = '0;
    if (ack_i) ack_mask[ack_idx_i] = 1'b1;
    if (clr_i)        irr_d = '0;
    else if (level_i) irr_d = ir_i & ~ack_mask;
    else              irr_d = (irr_o | (ir_i & ~prev_q)) & ~ack_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= ir_i;
      irr_o  <= irr_d;
    end
  end
endmodule

// File: rtl/pic8_arb.sv
module pic8_arb
  import pic8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [N_IRQ-1:0] irr_i,
  input  logic [N_IRQ-1:0] imr_i,
  input  logic             inta_i,
  input  logic             aeoi_i,
  input  logic             eoi_i,
  output logic             int_o,
  output logic             ack_ok_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [N_IRQ-1:0] isr_o
);
  pick_t pw, ps;
  logic [N_IRQ-1:0] isr_d;

  assign pw        = pick_first(irr_i & ~imr_i);
  assign ps        = pick_first(isr_o);
  assign win_idx_o = pw.idx;
  assign int_o     = run_i & pw.hit & (~ps.hit | (pw.idx < ps.idx));
  assign ack_ok_o  = inta_i & int_o;

  always_comb begin
    isr_d = isr_o;
    if (eoi_i && ps.hit)       isr_d[ps.idx] = 1'b0;
    if (ack_ok_o && !aeoi_i)   isr_d[pw.idx] = 1'b1;
    if (clr_i)                 isr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= isr_d;
  end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             a0_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o,
  output logic             dout_en_o,
  input  logic [N_IRQ-1:0] ir_i,
  input  logic             inta_i,
  output logic             int_o,
  input  logic             spen_i,
  output logic             spen_o,
  output logic             spen_oe_o,
  output logic             master_o
);
  logic              ready_w, clr_w, eoi_w, level_w, aeoi_w, buf_w, ms_w, ack_ok_w;
  logic [BASE_W-1:0] base_w;
  logic [N_IRQ-1:0]  imr_w, irr_w, isr_w;
  logic [IDX_W-1:0]  win_w;

  pic8_init u_init (
    .clk_i, .rst_ni,
    .wr_i    (cs_i & wr_i),
    .a0_i, .din_i,
    .ready_o (ready_w),
    .clr_o   (clr_w),
    .eoi_o   (eoi_w),
    .base_o  (base_w),
    .level_o (level_w),
    .aeoi_o  (aeoi_w),
    .buf_o   (buf_w),
    .ms_o    (ms_w),
    .imr_o   (imr_w)
  );

  pic8_irr u_irr (
    .clk_i, .rst_ni,
    .clr_i     (clr_w),
    .level_i   (level_w),
    .ir_i,
    .ack_i     (ack_ok_w),
    .ack_idx_i (win_w),
    .irr_o     (irr_w)
  );

  pic8_arb u_arb (
    .clk_i, .rst_ni,
    .clr_i     (clr_w),
    .run_i     (ready_w),
    .irr_i     (irr_w),
    .imr_i     (imr_w),
    .inta_i,
    .aeoi_i    (aeoi_w),
    .eoi_i     (eoi_w),
    .int_o,
    .ack_ok_o  (ack_ok_w),
    .win_idx_o (win_w),
    .isr_o     (isr_w)
  );

  assign dout_en_o = inta_i | (cs_i & rd_i);
  assign dout_o    = inta_i ? {base_w, win_w} : (a0_i ? imr_w : irr_w);
  assign spen_oe_o = buf_w;
  assign spen_o    = buf_w & dout_en_o;
  assign master_o  = buf_w ? ms_w : spen_i;
endmodule

// File: rtl/pic8_core_chk.sv
module pic8_core_chk
  import pic8_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             wr_i,
  input logic             a0_i,
  input logic [DW-1:0]    din_i,
  input logic             inta_i,
  input logic             int_o,
  input logic             aeoi,
  input logic [N_IRQ-1:0] isr,
  input logic [N_IRQ-1:0] imr
);
  p_init_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && din_i[4]) |=> !int_o);

  p_full_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr == '1) |-> !int_o);

  p_ack_sets_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !aeoi && !(cs_i && wr_i)) |=>
      ($countones(isr) == $past($countones(isr)) + 1));

  p_eoi_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && din_i == 8'h20 && isr != '0 && !inta_i) |=>
      ($countones(isr) == $past($countones(isr)) - 1));

  p_auto_eoi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi |-> (isr == '0));
endmodule

bind pic8_core pic8_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_i   (cs_i),
  .wr_i   (wr_i),
  .a0_i   (a0_i),
  .din_i  (din_i),
  .inta_i (inta_i),
  .int_o  (int_o),
  .aeoi   (aeoi_w),
  .isr    (isr_w),
  .imr    (imr_w)
);

// File: tb/pic8_core_tb.sv
`timescale 1ns/1ps
module pic8_core_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_i = 0, wr_i = 0, rd_i = 0, a0_i = 0, inta_i = 0, spen_i = 1;
  logic [7:0] din_i = 0, ir_i = 0;
  logic [7:0] dout_o;
  logic       dout_en_o, int_o, spen_o, spen_oe_o, master_o;

  always #2.5 clk_i = ~clk_i;

  pic8_core u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_ir = 0, m_irr = 0, m_isr = 0, m_imr = 0;
  bit m_aeoi = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); cs_i = 1; wr_i = 1; a0_i = a; din_i = d;
    @(negedge clk_i); cs_i = 0; wr_i = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk_i); cs_i = 1; rd_i = 1; a0_i = a;
    #1 v = dout_o;
    cs_i = 0; rd_i = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk_i); inta_i = 1;
    #1 v = dout_o;
    @(negedge clk_i); inta_i = 0;
  endtask

  task automatic set_ir(input logic [7:0] v);
    @(negedge clk_i); ir_i = v;
    @(negedge clk_i);
  endtask

  task automatic init(input logic [7:0] w1, w2, w3, w4);
    wr(0, w1); wr(1, w2);
    if (!w1[1]) wr(1, w3);
    if (w1[0])  wr(1, w4);
  endtask

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic exp_int();
    int w = low_idx(m_irr & ~m_imr);
    int s = low_idx(m_isr);
    return (w < 8) && (w < s);
  endfunction

  task automatic rand_run(input int n);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      case ($urandom % 5)
        0, 1: begin
          v = 8'($urandom);
          set_ir(v);
          m_irr |= v & ~m_ir; m_ir = v;
        end
        2: if (exp_int()) begin
          int w = low_idx(m_irr & ~m_imr);
          ack(v);
          chk("R3 random vector", v, 8'h08 | 8'(w));
          m_irr[w] = 0;
          if (!m_aeoi) m_isr[w] = 1;
        end
        3: begin
          wr(0, 8'h20);
          if (low_idx(m_isr) < 8) m_isr[low_idx(m_isr)] = 0;
        end
        default: begin
          v = 8'($urandom) & 8'($urandom);
          wr(1, v); m_imr = v;
        end
      endcase
      chk("R5 random int_o", {7'd0, int_o}, {7'd0, exp_int()});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset int_o", {7'd0, int_o}, 8'd0);
    chk("R12 reset dout_en", {7'd0, dout_en_o}, 8'd0);
    chk("R11 reset spen_oe", {7'd0, spen_oe_o}, 8'd0);
    chk("R11 strap high", {7'd0, master_o}, 8'd1);
    spen_i = 0; #1;
    chk("R11 strap low", {7'd0, master_o}, 8'd0);

    // single, no mode word
    init(8'h12, 8'h20, 8'h00, 8'h00);
    wr(1, 8'hFE); rd(1, v);
    chk("R2 skip both, IMR", v, 8'hFE);
    chk("R4 masked IR0 idle", {7'd0, int_o}, 8'd0);
    wr(1, 8'h00);
    set_ir(8'h01);
    chk("R8 edge raises int", {7'd0, int_o}, 8'd1);
    ack(v);
    chk("R3 vector IR0", v, 8'h20);
    chk("R6 in service blocks", {7'd0, int_o}, 8'd0);
    wr(0, 8'h20); set_ir(8'h00);

    // single with mode word
    init(8'h13, 8'h48, 8'h00, 8'h01);
    wr(1, 8'h3C); rd(1, v);
    chk("R2 skip cascade word", v, 8'h3C);

    // cascade with mode word
    init(8'h11, 8'h70, 8'h02, 8'h01);
    wr(1, 8'h5A); rd(1, v);
    chk("R2 all four words", v, 8'h5A);
    init(8'h11, 8'h70, 8'h02, 8'h01);
    rd(1, v);
    chk("R1 IMR cleared", v, 8'h00);

    // nesting and explicit EOI
    set_ir(8'h08);
    ack(v); chk("R3 vector IR3", v, 8'h73);
    set_ir(8'h00); set_ir(8'h08);
    chk("R5 same level blocked", {7'd0, int_o}, 8'd0);
    rd(0, v); chk("R12 IRR readback", v, 8'h08);
    set_ir(8'h0A);
    chk("R5 higher nests", {7'd0, int_o}, 8'd1);
    ack(v); chk("R3 vector IR1", v, 8'h71);
    wr(0, 8'h20);
    chk("R6 one EOI, IR3 still busy", {7'd0, int_o}, 8'd0);
    wr(0, 8'h20);
    chk("R6 second EOI releases", {7'd0, int_o}, 8'd1);
    ack(v); chk("R3 pending IR3", v, 8'h73);
    wr(0, 8'h20); set_ir(8'h00);
    set_ir(8'h84);
    ack(v); chk("R5 IR2 before IR7", v, 8'h72);
    chk("R5 IR7 under IR2", {7'd0, int_o}, 8'd0);
    wr(0, 8'h20);
    ack(v); chk("R5 IR7 after EOI", v, 8'h77);
    wr(0, 8'h20); set_ir(8'h00);

    // mask
    wr(1, 8'h10); set_ir(8'h10);
    chk("R4 mask blocks", {7'd0, int_o}, 8'd0);
    rd(0, v); chk("R12 masked still latched", v, 8'h10);
    wr(1, 8'h00);
    chk("R4 unmask releases", {7'd0, int_o}, 8'd1);
    ack(v); chk("R3 vector IR4", v, 8'h74);
    wr(0, 8'h20); set_ir(8'h00);

    // held level across re-init
    set_ir(8'h40);
    init(8'h11, 8'h70, 8'h02, 8'h01);
    chk("R8 held input no edge", {7'd0, int_o}, 8'd0);
    set_ir(8'h00); set_ir(8'h40);
    chk("R8 new edge", {7'd0, int_o}, 8'd1);
    ack(v); chk("R3 vector IR6", v, 8'h76);
    wr(0, 8'h20); set_ir(8'h00);

    // automatic EOI
    init(8'h13, 8'h08, 8'h00, 8'h03);
    set_ir(8'h20);
    ack(v); chk("R3 vector IR5", v, 8'h0D);
    set_ir(8'h00); set_ir(8'h20);
    chk("R7 refires without EOI", {7'd0, int_o}, 8'd1);
    ack(v); set_ir(8'h00);

    // level mode
    init(8'h1B, 8'h08, 8'h00, 8'h03);
    set_ir(8'h04);
    chk("R9 level raises", {7'd0, int_o}, 8'd1);
    ack(v); chk("R3 level vector", v, 8'h0A);
    @(negedge clk_i);
    chk("R9 still high re-raises", {7'd0, int_o}, 8'd1);
    set_ir(8'h00);
    chk("R9 falling withdraws", {7'd0, int_o}, 8'd0);

    // SP/EN roles
    spen_i = 0;
    init(8'h13, 8'h08, 8'h00, 8'h0D);
    chk("R10 oe in buffered", {7'd0, spen_oe_o}, 8'd1);
    chk("R10 role from word", {7'd0, master_o}, 8'd1);
    chk("R10 idle enable", {7'd0, spen_o}, 8'd0);
    @(negedge clk_i); cs_i = 1; rd_i = 1; a0_i = 1; #1;
    chk("R10 enable on read", {7'd0, spen_o}, 8'd1);
    chk("R12 dout_en on read", {7'd0, dout_en_o}, 8'd1);
    cs_i = 0; rd_i = 0;
    spen_i = 1;
    init(8'h13, 8'h08, 8'h00, 8'h09);
    chk("R10 slave despite strap", {7'd0, master_o}, 8'd0);
    init(8'h13, 8'h08, 8'h00, 8'h01);
    chk("R11 oe off", {7'd0, spen_oe_o}, 8'd0);
    chk("R11 strap master", {7'd0, master_o}, 8'd1);
    spen_i = 0; #1;
    chk("R11 strap slave", {7'd0, master_o}, 8'd0);

    // random, explicit then automatic EOI
    set_ir(8'h00); m_ir = 0;
    init(8'h11, 8'h08, 8'h04, 8'h01);
    m_irr = 0; m_isr = 0; m_imr = 0; m_aeoi = 0;
    rand_run(500);
    init(8'h11, 8'h08, 8'h04, 8'h03);
    m_irr = 0; m_isr = 0; m_imr = 0; m_aeoi = 1;
    rand_run(500);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule